// File: doc/BRIEF.md
# Maskable Priority Interrupt Controller

This block gathers interrupt requests from three groups of maskable sources (external request pins, wake-up pins and on-chip peripherals) plus a single non-maskable input. Each maskable source passes through its own enable bit. The CPU's global mask bit is an input. While it is 1, only the non-maskable input may be accepted.

The controller accepts only at instruction boundaries, signalled by a one-cycle completion strobe from the CPU. When a request can be accepted, the block picks the winner by fixed priority. It then raises a registered take signal together with the winner's vector address, and pulses a mask-set strobe so that the CPU raises its global mask. Take and vector stay steady until the CPU acknowledges. Maskable requests are level-sensitive, and their sources clear them. The non-maskable input is edge-detected and latched until it is accepted.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, take, mask-set and the vector address are all 0.
- R2: A maskable source whose enable bit is 0 is never accepted, whatever its request line does.
- R3: While the mask input is 1, no maskable request is accepted, but a pending non-maskable event is. A maskable request held through the masked period is accepted once the mask returns to 0.
- R4: Fixed priority, highest first: the non-maskable event, then the external pins, then the wake-up pins, then the peripherals. Within each group, the lower index wins.
- R5: Acceptance happens only on a clock edge where the completion strobe is 1. Take rises one cycle after that edge.
- R6: The mask-set strobe is high for exactly one cycle: the first cycle in which take is high.
- R7: The vector address is BASE_ADDR + 4*number. The number is VN_NMI for the non-maskable input, VN_IRQ+k for external pin k, VN_WAKE+k for wake-up pin k and VN_PER+k for peripheral k. The defaults are 0x100, 7, 16, 32 and 48.
- R8: While take is high and acknowledge is low, take stays high and the vector does not change, and no new acceptance happens. Take falls one cycle after an edge that samples acknowledge at 1.
- R9: A rising edge on the non-maskable input is remembered until it is accepted, even if the pulse lasts only one cycle. A level held high gives only one acceptance.
- R10: A non-maskable edge that arrives while an earlier interrupt is still unacknowledged stays pending and is accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_in | input | 1 | Non-maskable interrupt input, rising-edge sensitive |
| irq_req | input | N_IRQ | External pin requests, level |
| irq_en | input | N_IRQ | External pin enable bits |
| wake_req | input | N_WAKE | Wake-up pin requests, level |
| wake_en | input | N_WAKE | Wake-up pin enable bits |
| per_req | input | N_PER | Peripheral requests, level |
| per_en | input | N_PER | Peripheral enable bits |
| mask_i | input | 1 | CPU global mask bit; 1 blocks maskable sources |
| insn_done | input | 1 | Instruction-complete strobe |
| ack | input | 1 | CPU acknowledge of the offered interrupt |
| take_o | output | 1 | Interrupt offered to the CPU |
| vec_addr_o | output | ADDR_W | Vector table address of the offered interrupt |
| mask_set_o | output | 1 | One-cycle request to set the CPU global mask |

## Verification
The assertions assume that the CPU raises acknowledge only while take is high. They also assume that the mask input reflects the CPU's own bit, so that the masked-acceptance property can read it one cycle back. The stimulus changes every input on the falling clock edge and asserts acknowledge only after it has seen take. It drives the mask input directly, as the CPU would after the mask-set strobe. The other properties (hold until acknowledge, strobe alignment, boundary-only acceptance, encoder consistency and non-maskable retention) need nothing from the inputs beyond reset being applied first.

// File: rtl/intc_pkg.sv
package intc_pkg;
    // Class of the source that wins arbitration in a cycle.
    typedef enum logic [1:0] {
        WIN_NONE     = 2'd0,
        WIN_NMI      = 2'd1,
        WIN_MASKABLE = 2'd2
    } win_kind_e;

    // Vector address from a vector number: base plus four bytes per entry.
    function automatic int vec_to_addr(input int base, input int num);
        return base + num * 4;
    endfunction
endpackage

// File: rtl/intc_nmi_latch.sv
module intc_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic consume,
    output logic live_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_state_t;

    nmi_state_t st_d, st_q;
    logic       edge_seen;

    always_comb begin
        st_d      = st_q;
        edge_seen = nmi_in & ~st_q.prev;
        live_o    = st_q.pend | edge_seen;
        st_d.prev = nmi_in;
        st_d.pend = consume ? 1'b0 : live_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9/R10: a pending event survives every cycle in which it is not consumed
    assert_nmi_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_o && !consume) |=> live_o);
    // R9: consumption only of something that is live
    assert_nmi_consume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> live_o);
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
    parameter int W     = 20,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     req,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top down so the lowest set index is the last to write.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_vec_map.sv
module intc_vec_map #(
    parameter int N_IRQ     = 8,
    parameter int N_WAKE    = 4,
    parameter int N_PER     = 8,
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h100,
    parameter int VN_NMI    = 7,
    parameter int VN_IRQ    = 16,
    parameter int VN_WAKE   = 32,
    parameter int VN_PER    = 48,
    localparam int N_TOT    = N_IRQ + N_WAKE + N_PER,
    localparam int IDX_W    = (N_TOT > 1) ? $clog2(N_TOT) : 1
) (
    input  logic              is_nmi,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr_o
);
    import intc_pkg::*;

    // Per-source constant vector addresses, one per flat index.
    logic [ADDR_W-1:0] tbl [N_TOT];

    for (genvar g = 0; g < N_TOT; g++) begin : g_tbl
        if (g < N_IRQ) begin : g_irq
            assign tbl[g] = ADDR_W'(vec_to_addr(BASE_ADDR, VN_IRQ + g));
        end else if (g < N_IRQ + N_WAKE) begin : g_wake
            assign tbl[g] = ADDR_W'(vec_to_addr(BASE_ADDR, VN_WAKE + g - N_IRQ));
        end else begin : g_per
            assign tbl[g] = ADDR_W'(vec_to_addr(BASE_ADDR, VN_PER + g - N_IRQ - N_WAKE));
        end
    end

    always_comb begin
        addr_o = '0;
        if (is_nmi) begin
            addr_o = ADDR_W'(vec_to_addr(BASE_ADDR, VN_NMI));
        end else begin
            for (int i = 0; i < N_TOT; i++) begin
                if (int'(idx) == i) addr_o = tbl[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int N_IRQ     = 8,
    parameter int N_WAKE    = 4,
    parameter int N_PER     = 8,
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h100,
    parameter int VN_NMI    = 7,
    parameter int VN_IRQ    = 16,
    parameter int VN_WAKE   = 32,
    parameter int VN_PER    = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic [N_WAKE-1:0] wake_req,
    input  logic [N_WAKE-1:0] wake_en,
    input  logic [N_PER-1:0]  per_req,
    input  logic [N_PER-1:0]  per_en,
    input  logic              mask_i,
    input  logic              insn_done,
    input  logic              ack,
    output logic              take_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              mask_set_o
);
    import intc_pkg::*;

    localparam int N_TOT = N_IRQ + N_WAKE + N_PER;
    localparam int IDX_W = (N_TOT > 1) ? $clog2(N_TOT) : 1;
    localparam logic [ADDR_W-1:0] NMI_ADDR = ADDR_W'(vec_to_addr(BASE_ADDR, VN_NMI));

    typedef struct packed {
        logic              take;
        logic              mask_set;
        logic [ADDR_W-1:0] vec;
    } ctl_state_t;

    ctl_state_t        st_d, st_q;
    logic [N_TOT-1:0]  req_flat;
    logic              enc_valid;
    logic [IDX_W-1:0]  enc_idx;
    logic              nmi_live;
    logic              nmi_consume;
    logic [ADDR_W-1:0] map_addr;
    win_kind_e         winner;
    logic              accept;

    // Flat request order encodes priority: pins, then wake-up, then peripherals.
    assign req_flat = {per_req & per_en, wake_req & wake_en, irq_req & irq_en};

    intc_prio_enc #(.W(N_TOT), .IDX_W(IDX_W)) u_enc (
        .req     (req_flat),
        .valid_o (enc_valid),
        .idx_o   (enc_idx)
    );

    intc_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_in  (nmi_in),
        .consume (nmi_consume),
        .live_o  (nmi_live)
    );

    intc_vec_map #(
        .N_IRQ(N_IRQ), .N_WAKE(N_WAKE), .N_PER(N_PER), .ADDR_W(ADDR_W),
        .BASE_ADDR(BASE_ADDR), .VN_NMI(VN_NMI), .VN_IRQ(VN_IRQ),
        .VN_WAKE(VN_WAKE), .VN_PER(VN_PER)
    ) u_map (
        .is_nmi (winner == WIN_NMI),
        .idx    (enc_idx),
        .addr_o (map_addr)
    );

    always_comb begin
        if (nmi_live)                 winner = WIN_NMI;
        else if (enc_valid && !mask_i) winner = WIN_MASKABLE;
        else                          winner = WIN_NONE;

        accept      = !st_q.take && insn_done && (winner != WIN_NONE);
        nmi_consume = accept && (winner == WIN_NMI);

        st_d          = st_q;
        st_d.mask_set = 1'b0;
        if (st_q.take && ack) st_d.take = 1'b0;
        if (accept) begin
            st_d.take     = 1'b1;
            st_d.mask_set = 1'b1;
            st_d.vec      = map_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o     = st_q.take;
    assign vec_addr_o = st_q.vec;
    assign mask_set_o = st_q.mask_set;

    // R8: offer held steady until acknowledged
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !ack) |=> (take_o && $stable(vec_addr_o)));
    // R8: acknowledge withdraws the offer on the next cycle
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack) |=> !take_o);
    // R5: a new offer starts only after an instruction boundary
    assert_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> $past(insn_done));
    // R6: mask-set strobe lines up with the rising take
    assert_maskset_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> mask_set_o);
    assert_maskset_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set_o |-> (take_o && !$past(take_o)));
    // R3: with the mask set only the non-maskable vector may be offered
    assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(take_o) && $past(mask_i)) |-> (vec_addr_o == NMI_ADDR));
    // R4: the encoder index points at a live request with none below it
    assert_enc_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> req_flat[enc_idx]);
    assert_enc_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> ((req_flat & ((N_TOT'(1) << enc_idx) - N_TOT'(1))) == '0));
    // R2: the encoder is idle when no enabled request exists
    assert_enc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_flat == '0) |-> !enc_valid);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
    localparam int NI = 8, NW = 4, NP = 8, NT = NI + NW + NP;
    localparam int BASE = 'h100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic nmi = 1'b0, mask = 1'b0, idone = 1'b0, ack = 1'b0;
    logic [NT-1:0] req_f = '0, en_f = '1;
    logic take, mset;
    logic [15:0] vec;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi),
        .irq_req(req_f[NI-1:0]), .irq_en(en_f[NI-1:0]),
        .wake_req(req_f[NI+NW-1:NI]), .wake_en(en_f[NI+NW-1:NI]),
        .per_req(req_f[NT-1:NI+NW]), .per_en(en_f[NT-1:NI+NW]),
        .mask_i(mask), .insn_done(idone), .ack(ack),
        .take_o(take), .vec_addr_o(vec), .mask_set_o(mset)
    );

    function automatic int exp_addr(input int k);
        if (k < 0)            return BASE + 7 * 4;
        else if (k < NI)      return BASE + (16 + k) * 4;
        else if (k < NI + NW) return BASE + (32 + k - NI) * 4;
        else                  return BASE + (48 + k - NI - NW) * 4;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // Strobe one boundary; expect an offer (k = -1 for the NMI) or none.
    task automatic boundary(input bit exp_take, input int k, input string rq);
        idone = 1'b1;
        @(negedge clk);
        idone = 1'b0;
        chk(take == exp_take, rq, int'(take), int'(exp_take));
        if (exp_take) begin
            chk(vec == 16'(exp_addr(k)), rq, int'(vec), exp_addr(k));
            chk(mset == 1'b1, {rq, " mask-set R6"}, int'(mset), 1);
            ack = 1'b1;
            @(negedge clk);
            ack = 1'b0;
            chk(take == 1'b0 && mset == 1'b0, {rq, " release R8"}, int'(take), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, all requirements");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(take == 0 && mset == 0 && vec == 0, "R1 in reset", int'(vec), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(take == 0 && mset == 0 && vec == 0, "R1 after reset", int'(vec), 0);

        // R7: each single source yields its own vector
        for (int k = 0; k < NT; k++) begin
            req_f = NT'(1) << k;
            boundary(1'b1, k, "R7 single source");
        end
        req_f = '0;

        // R2: a disabled source is never taken
        for (int k = 0; k < NT; k++) begin
            req_f = NT'(1) << k;
            en_f  = ~(NT'(1) << k);
            boundary(1'b0, k, "R2 disabled source");
        end
        req_f = '1; en_f = '0;
        boundary(1'b0, 0, "R2 all disabled");
        req_f = '0; en_f = '1;

        // R4: every pair, the lower flat index wins
        for (int a = 0; a < NT; a++) begin
            for (int b = a + 1; b < NT; b++) begin
                req_f = (NT'(1) << a) | (NT'(1) << b);
                boundary(1'b1, a, "R4 pair priority");
            end
        end

        // R5: no acceptance without the completion strobe
        req_f = NT'(1) << 5;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(take == 0, "R5 no boundary", int'(take), 0);
        end
        boundary(1'b1, 5, "R5 boundary taken");

        // R3: masked, only the NMI gets through; held request follows later
        req_f = '1; mask = 1'b1;
        boundary(1'b0, 0, "R3 masked maskable");
        nmi = 1'b1; @(negedge clk); nmi = 1'b0;
        @(negedge clk);
        chk(take == 0, "R9 pulse not yet taken", int'(take), 0);
        boundary(1'b1, -1, "R3 NMI through mask");
        mask = 1'b0;
        boundary(1'b1, 0, "R3 unmasked after mask");

        // R4: NMI beats every maskable source
        nmi = 1'b1; @(negedge clk); nmi = 1'b0;
        boundary(1'b1, -1, "R4 NMI highest");

        // R8: hold until acknowledge, with inputs changing meanwhile
        req_f = NT'(1) << 3;
        idone = 1'b1; @(negedge clk); idone = 1'b0;
        chk(take == 1 && vec == 16'(exp_addr(3)), "R8 offered", int'(vec), exp_addr(3));
        req_f = NT'(1) << 0;
        for (int c = 0; c < 5; c++) begin
            idone = c[0];
            @(negedge clk);
            chk(take == 1 && vec == 16'(exp_addr(3)), "R8 held", int'(vec), exp_addr(3));
            chk(mset == 0, "R6 single-cycle strobe", int'(mset), 0);
        end
        idone = 1'b0;
        // R10: NMI edge while outstanding stays pending
        nmi = 1'b1; @(negedge clk); nmi = 1'b0;
        chk(take == 1 && vec == 16'(exp_addr(3)), "R10 offer unchanged", int'(vec), exp_addr(3));
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk(take == 0, "R8 released", int'(take), 0);
        mask = 1'b1;
        boundary(1'b1, -1, "R10 pending NMI taken");

        // R9: NMI level held high is taken only once
        req_f = '0;
        nmi = 1'b1;
        boundary(1'b1, -1, "R9 level first");
        boundary(1'b0, -1, "R9 level no repeat");
        nmi = 1'b0;
        boundary(1'b0, -1, "R9 nothing pending");
        mask = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule